// File: doc/BRIEF.md
# Sectored External Memory Wait-State Controller

This block sits between a processor core and an external parallel memory bus. The core issues one-cycle requests carrying a write flag, a 16-bit address and write data. The controller turns each request into a strobed bus access. It first places the address on the bus for one cycle, then asserts the read or write strobe. It raises `ready` for one cycle in the last strobe cycle. For reads, `rdata` carries the bus input during that `ready` cycle.

The external window runs from 0x1100 to 0xFFFF. A 3-bit boundary setting divides the window into a low region and a high region. Each region has its own 2-bit wait code. The wait code can lengthen the strobe, and its highest value also adds one idle cycle before the new address reaches the bus. Requests below 0x1100 belong to on-chip memory. They are acknowledged without touching the external bus.

The boundary setting and both wait codes are taken in the cycle the request is accepted. They then stay fixed for that access, whatever the inputs do later.

Top module: `xmem_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `ext_rd`, `ext_wr` and `ready` are low, and `ext_addr` is 0.
- R2: A request with address below 0x1100 gives `ready` in the cycle after the request. It asserts no strobe and leaves `ext_addr` unchanged.
- R3: The high region is chosen when `bnd_sel` is 0, or when the address is at least `bnd_sel` × 0x2000. Any other address from 0x1100 upward is in the low region. `wait_hi` applies to the high region and `wait_lo` to the low region.
- R4: With wait codes 00, 01 and 10, the strobe stays active for 1, 2 and 3 consecutive cycles respectively.
- R5: Wait code 11 keeps the strobe active for 3 cycles. It also adds one cycle directly after the request in which no strobe is active and `ext_addr` still holds the previous external address.
- R6: The new address appears on `ext_addr` exactly one cycle before the first strobe cycle. It stays unchanged while the strobe is active.
- R7: `ready` is high for exactly one cycle, and that cycle is the last strobe cycle. In that cycle of a read, `rdata` equals `ext_din`.
- R8: A read asserts only `ext_rd` and a write asserts only `ext_wr`; the two are never high together. During write strobes, `ext_dout` carries the request's write data.
- R9: Changes to `bnd_sel`, `wait_lo`, `wait_hi`, `addr`, `we` or `wdata` after the request cycle have no effect on the access in progress.
- R10: A request raised while an access is in progress is ignored. In the cycle after `ready`, the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | One-cycle access request, taken when idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with `ready` on reads |
| ready | output | 1 | One-cycle completion pulse |
| bnd_sel | input | 3 | Region boundary setting |
| wait_lo | input | 2 | Wait code for the low region |
| wait_hi | input | 2 | Wait code for the high region |
| ext_addr | output | 16 | External bus address |
| ext_dout | output | 8 | External bus write data |
| ext_din | input | 8 | External bus read data |
| ext_rd | output | 1 | Read strobe, active high |
| ext_wr | output | 1 | Write strobe, active high |

## Verification
Counting from the request cycle as cycle 0, an internal access shows `ready` in cycle 1. An external access with wait code c shows its new address in cycle 1+p, where p is 1 for code 11 and 0 otherwise. Its strobe occupies cycles 2+p through 1+p+s, where s is the strobe length 1, 2, 3 or 3 for codes 00, 01, 10 and 11. `ready` and read data fall in cycle 1+p+s.

The bench drives inputs on falling edges and samples every cycle on falling edges. It records the cycle where the address first appears, the number of strobe cycles and the `ready` cycle, then compares each to these formulas. It also checks that the cycle after `ready` is idle.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    localparam int XM_AW = 16;
    localparam int XM_DW = 8;
    localparam int XM_CW = 2;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_INT,
        XS_PRE,
        XS_SETUP,
        XS_STROBE
    } xm_state_e;

    typedef struct packed {
        logic             wr;
        logic [XM_AW-1:0] adr;
        logic [XM_DW-1:0] dat;
        logic [1:0]       code;
    } xm_job_t;

    // extra strobe cycles beyond the first
    function automatic logic [XM_CW-1:0] xm_extra(input logic [1:0] code);
        logic [XM_CW-1:0] n;
        case (code)
            2'b00:   n = XM_CW'(0);
            2'b01:   n = XM_CW'(1);
            default: n = XM_CW'(2);
        endcase
        return n;
    endfunction

    function automatic logic xm_has_pre(input logic [1:0] code);
        return code == 2'b11;
    endfunction

endpackage

// File: rtl/xmem_region_dec.sv
module xmem_region_dec #(
    parameter int AW    = 16,
    parameter int LW    = 3,
    parameter int SHIFT = 13,
    parameter int BASE  = 'h1100
) (
    input  logic [AW-1:0] adr,
    input  logic [LW-1:0] bnd,
    output logic          on_chip,
    output logic          high
);
    localparam int EW = AW + 1;

    logic [EW-1:0] edge_adr;

    always_comb begin
        edge_adr = EW'(bnd) << SHIFT;
        on_chip  = EW'(adr) < EW'(BASE);
        high     = (bnd == '0) || (EW'(adr) >= edge_adr);
    end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             on_chip,
    input  xm_job_t          job_in,
    output xm_job_t          job,
    output xm_state_e        st,
    output logic             last,
    output logic [XM_AW-1:0] bus_adr
);
    logic [XM_CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= XS_IDLE;
            left    <= '0;
            job     <= '0;
            bus_adr <= '0;
        end else begin
            unique case (st)
                XS_IDLE: begin
                    if (start) begin
                        job <= job_in;
                        if (on_chip) begin
                            st <= XS_INT;
                        end else if (xm_has_pre(job_in.code)) begin
                            st <= XS_PRE;
                        end else begin
                            st      <= XS_SETUP;
                            bus_adr <= job_in.adr;
                        end
                    end
                end
                XS_INT:   st <= XS_IDLE;
                XS_PRE: begin
                    st      <= XS_SETUP;
                    bus_adr <= job.adr;
                end
                XS_SETUP: begin
                    st   <= XS_STROBE;
                    left <= xm_extra(job.code);
                end
                XS_STROBE: begin
                    if (left == '0) st <= XS_IDLE;
                    else            left <= left - 1'b1;
                end
                default:  st <= XS_IDLE;
            endcase
        end
    end

    assign last = (st == XS_STROBE) && (left == '0);
endmodule

// File: rtl/xmem_strobe_gen.sv
module xmem_strobe_gen
    import xmem_pkg::*;
(
    input  xm_state_e        st,
    input  logic             last,
    input  xm_job_t          job,
    input  logic [XM_DW-1:0] din,
    output logic             rd_n_act,
    output logic             wr_act,
    output logic [XM_DW-1:0] dout,
    output logic [XM_DW-1:0] rdat,
    output logic             done
);
    logic strobing, driving;

    always_comb begin
        strobing = (st == XS_STROBE);
        driving  = (st == XS_SETUP) || strobing;
        rd_n_act = strobing && !job.wr;
        wr_act   = strobing && job.wr;
        dout     = (driving && job.wr) ? job.dat : '0;
        rdat     = (last && !job.wr) ? din : '0;
        done     = last || (st == XS_INT);
    end
endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
    import xmem_pkg::*;
#(
    parameter int AW    = XM_AW,
    parameter int DW    = XM_DW,
    parameter int LW    = 3,
    parameter int SHIFT = 13,
    parameter int BASE  = 'h1100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          ready,
    input  logic [LW-1:0] bnd_sel,
    input  logic [1:0]    wait_lo,
    input  logic [1:0]    wait_hi,
    output logic [AW-1:0] ext_addr,
    output logic [DW-1:0] ext_dout,
    input  logic [DW-1:0] ext_din,
    output logic          ext_rd,
    output logic          ext_wr
);
    logic      on_chip, high, last;
    xm_job_t   job_in, job;
    xm_state_e st;

    xmem_region_dec #(.AW(AW), .LW(LW), .SHIFT(SHIFT), .BASE(BASE)) i_dec (
        .adr     (addr),
        .bnd     (bnd_sel),
        .on_chip (on_chip),
        .high    (high)
    );

    always_comb begin
        job_in.wr   = we;
        job_in.adr  = addr;
        job_in.dat  = wdata;
        job_in.code = high ? wait_hi : wait_lo;
    end

    xmem_seq i_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (req),
        .on_chip (on_chip),
        .job_in  (job_in),
        .job     (job),
        .st      (st),
        .last    (last),
        .bus_adr (ext_addr)
    );

    xmem_strobe_gen i_stb (
        .st       (st),
        .last     (last),
        .job      (job),
        .din      (ext_din),
        .rd_n_act (ext_rd),
        .wr_act   (ext_wr),
        .dout     (ext_dout),
        .rdat     (rdata),
        .done     (ready)
    );
endmodule

// File: rtl/xmem_ctrl_chk.sv
module xmem_ctrl_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          ready,
    input logic          ext_rd,
    input logic          ext_wr,
    input logic [AW-1:0] ext_addr
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!ext_rd && !ext_wr && !ready && ext_addr == '0)); // R1

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ext_rd && ext_wr)); // R8

    AST_ADDR_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_rd || ext_wr) |-> $stable(ext_addr)); // R6

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (ext_rd || ext_wr) |=> $stable(ext_addr)); // R6

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready); // R7

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (ready && (ext_rd || ext_wr)) |=> !(ext_rd || ext_wr)); // R10
endmodule

bind xmem_ctrl xmem_ctrl_chk #(.AW(AW)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .ready    (ready),
    .ext_rd   (ext_rd),
    .ext_wr   (ext_wr),
    .ext_addr (ext_addr)
);

// File: tb/test_xmem_ctrl.sv
module test_xmem_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, req, we;
    logic [15:0] addr, ext_addr;
    logic [7:0]  wdata, rdata, ext_dout, ext_din;
    logic        ready, ext_rd, ext_wr;
    logic [2:0]  bnd_sel;
    logic [1:0]  wait_lo, wait_hi;

    int          errs = 0;
    int          checks = 0;
    logic [15:0] prev_ext = 16'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xmem_ctrl i_xmem_ctrl (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ready(ready), .bnd_sel(bnd_sel), .wait_lo(wait_lo),
        .wait_hi(wait_hi), .ext_addr(ext_addr), .ext_dout(ext_dout),
        .ext_din(ext_din), .ext_rd(ext_rd), .ext_wr(ext_wr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit f_int(input int a);
        return a < 32'h1100;
    endfunction
    function automatic bit f_high(input int a, input int b);
        return (b == 0) || (a >= b * 8192);
    endfunction
    function automatic int f_stb(input int c);
        if (c == 0) return 1;
        if (c == 1) return 2;
        return 3;
    endfunction
    function automatic int f_pre(input int c);
        return (c == 3) ? 1 : 0;
    endfunction

    task automatic access(input bit w, input logic [15:0] a_in, input logic [7:0] d,
                          input int b, input int cl, input int ch);
        logic [15:0] a;
        logic [7:0]  din;
        bit   internal;
        int   code, pre, stb, exp_rdy, c, rdy_c, first_a, strobes, bad;
        a = a_in;
        if (a == prev_ext) a[0] = ~a[0];
        internal = f_int(a);
        code     = f_high(a, b) ? ch : cl;
        pre      = f_pre(code);
        stb      = f_stb(code);
        exp_rdy  = internal ? 1 : 1 + pre + stb;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        bnd_sel = 3'(b); wait_lo = 2'(cl); wait_hi = 2'(ch);
        ext_din = 8'($urandom);
        din = ext_din;
        @(negedge clk);
        // R9: disturb every input after the request cycle
        req = 1'b0; we = ~w; addr = 16'($urandom); wdata = 8'($urandom);
        bnd_sel = 3'($urandom); wait_lo = 2'($urandom); wait_hi = 2'($urandom);
        rdy_c = 0; first_a = 0; strobes = 0; bad = 0;
        for (c = 1; c <= 12; c++) begin
            if (ext_rd || ext_wr) strobes++;
            if ((ext_rd && ext_wr) || (ext_rd && w) || (ext_wr && !w)) bad++;
            if (ext_wr && ext_dout != d) bad++;
            if (first_a == 0 && ext_addr == a) first_a = c;
            if (ready) begin
                rdy_c = c;
                if (!w && !internal)
                    chk(rdata == din, "R7 rdata", rdata, din);
                if (internal)
                    chk(ext_addr == prev_ext, "R2 ext_addr", ext_addr, prev_ext);
                break;
            end
            // R10: a request while busy
            req  = (c == 2);
            addr = 16'($urandom);
            @(negedge clk);
        end
        req = 1'b0;
        chk(rdy_c == exp_rdy, "R3/R4/R5/R9 ready cycle", rdy_c, exp_rdy);
        chk(strobes == (internal ? 0 : stb), "R4/R5 strobe length", strobes,
            internal ? 0 : stb);
        chk(first_a == (internal ? 0 : 1 + pre), "R5/R6 address cycle", first_a,
            internal ? 0 : 1 + pre);
        chk(bad == 0, "R8 strobe kind/data", bad, 0);
        @(negedge clk);
        chk(!ready && !ext_rd && !ext_wr, "R10 idle after ready",
            {ready, ext_rd, ext_wr}, 0);
        if (!internal) prev_ext = a;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int base, lo;
        void'($urandom(32'd4242));
        rst = 1'b1; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        bnd_sel = '0; wait_lo = '0; wait_hi = '0; ext_din = '0;
        repeat (3) @(negedge clk);
        chk(!ext_rd && !ext_wr && !ready && ext_addr == 16'h0, "R1 reset state",
            {ext_rd, ext_wr, ready}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!ext_rd && !ext_wr && !ready && ext_addr == 16'h0, "R1 after reset",
            ext_addr, 0);

        // R3 sweep of boundary setting and both wait codes
        for (int b = 0; b < 8; b++)
            for (int cl = 0; cl < 4; cl++)
                for (int ch = 0; ch < 4; ch++) begin
                    base = b * 8192;
                    if (b != 0)
                        access(1'($urandom), 16'(32'h1100 + $urandom % (base - 32'h1100)),
                               8'($urandom), b, cl, ch);
                    lo = (b == 0) ? 32'h1100 : base;
                    access(1'($urandom), 16'(lo + $urandom % (65536 - lo)),
                           8'($urandom), b, cl, ch);
                end

        // R3 boundary edges with distinct codes
        for (int b = 1; b < 8; b++) begin
            access(1'b0, 16'(b * 8192 - 1), 8'h5A, b, 0, 3);
            access(1'b1, 16'(b * 8192), 8'hA5, b, 0, 3);
            access(1'b0, 16'h1100, 8'h11, b, 2, 1);
        end
        access(1'b0, 16'h1100, 8'h00, 0, 3, 0);
        access(1'b1, 16'hFFFF, 8'hFF, 7, 0, 2);

        // R2 on-chip addresses
        access(1'b0, 16'h10FF, 8'h33, 3, 3, 3);
        access(1'b1, 16'h0000, 8'h44, 0, 1, 2);

        for (int i = 0; i < 300; i++)
            access(1'($urandom), 16'($urandom), 8'($urandom), int'($urandom % 8),
                   int'($urandom % 4), int'($urandom % 4));

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule